// File: doc/BRIEF.md
# Serial Port Pin Multiplexer with GPIO

This block owns eight device pins and hands each one either to general-purpose I/O or to one of three serial peripherals: an SPI unit and two asynchronous serial interfaces (called serial interface 1 and serial interface 0). Each peripheral has one enable input. When it is asserted, the peripheral takes a fixed group of pins ahead of GPIO. Pins in no enabled group are driven from a data register and a direction register.

Software reaches the port through a small register bus. Reads are combinational and writes take effect on the clock edge. Pin levels pass through a two-flop synchronizer. The synchronized value feeds register reads and the peripheral receive paths. On a data-register read, output bits return the latched value and input bits return the synchronized pin level. A separate read-only register always returns the synchronized pins.

Top module: `serial_pin_mux`

## Requirements
- R1: While reset is held and just after it is released, with no peripheral enabled, every `pin_oe_o` bit is 0 and the direction register (address 2) reads 0.
- R2: On a GPIO-owned pin n, `pin_oe_o[n]` equals direction bit n and `pin_out_o[n]` equals data register bit n.
- R3: With `spi_en_i` high, pin 4+k has `pin_out_o` = `spi_out_i[k]` and `pin_oe_o` = `spi_oe_i[k]` for k = 0..3. Bit 3 is slave select on pin 7, bit 2 is the serial clock on pin 6, bit 1 is master-out on pin 5 and bit 0 is master-in on pin 4.
- R4: With `ser1_en_i` high, pin 3 drives `ser1_txd_i` with enable `ser1_tx_oe_i`, and pin 2 is forced to input (oe 0, out 0).
- R5: With `ser0_en_i` high, pin 1 drives `ser0_txd_i` with enable `ser0_tx_oe_i`, and pin 0 is forced to input (oe 0, out 0).
- R6: Each enable takes over only its own pin group. All other pins stay under GPIO control, whatever combination of enables is active.
- R7: A read of address 0 returns, bit by bit, the data register where the direction bit is 1 and the synchronized pin level where it is 0.
- R8: Address 1 returns the synchronized pin levels. Writes to address 1 change neither the data nor the direction register.
- R9: The direction register at address 2 is written and read back unchanged.
- R10: Address 3 reads zero, and writes to it change no register.
- R11: A pin change is visible on reads and on `spi_in_o`, `ser1_rxd_o` and `ser0_rxd_o` after exactly two rising clock edges, and not after one. `spi_in_o[k]` follows pin 4+k, `ser1_rxd_o` follows pin 2 and `ser0_rxd_o` follows pin 0. These outputs follow the pins whether or not the peripheral is enabled.
- R12: The data register keeps its contents through a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| spi_en_i | input | 1 | SPI owns pins 7..4 |
| ser1_en_i | input | 1 | Serial interface 1 owns pins 3..2 |
| ser0_en_i | input | 1 | Serial interface 0 owns pins 1..0 |
| spi_out_i | input | 4 | SPI pin output values, bit k for pin 4+k |
| spi_oe_i | input | 4 | SPI pin output enables, bit k for pin 4+k |
| ser1_txd_i | input | 1 | Serial interface 1 transmit data |
| ser1_tx_oe_i | input | 1 | Serial interface 1 transmit enable |
| ser0_txd_i | input | 1 | Serial interface 0 transmit data |
| ser0_tx_oe_i | input | 1 | Serial interface 0 transmit enable |
| pin_in_i | input | 8 | Pad input levels |
| pin_out_o | output | 8 | Pad output values |
| pin_oe_o | output | 8 | Pad output enables |
| spi_in_o | output | 4 | Synchronized pins 7..4 to SPI |
| ser1_rxd_o | output | 1 | Synchronized pin 2 to serial interface 1 |
| ser0_rxd_o | output | 1 | Synchronized pin 0 to serial interface 0 |

## Verification
The hardest state to reach is a mixed read of address 0. Some bits there must come from the latched register and others from live pins that disagree with it. The bench therefore sweeps all 256 direction values and drives pins that are the complement of the latched data, so that every wrong bit choice shows up. Data retention across reset is also awkward to observe, because the direction register clears. The bench writes a pattern, pulses reset, then sets all bits to output and reads the pattern back.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int unsigned PORT_W = 8;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_PIN  = 2'd1;
  localparam logic [1:0] ADDR_DIR  = 2'd2;

  typedef enum logic [1:0] {
    OWN_GPIO = 2'd0,
    OWN_SPI  = 2'd1,
    OWN_SER1 = 2'd2,
    OWN_SER0 = 2'd3
  } owner_e;

  // fixed group of each pin; ownership is taken only if that group is enabled
  function automatic owner_e pin_group(input int unsigned idx);
    if (idx >= 4) return OWN_SPI;
    else if (idx >= 2) return OWN_SER1;
    else return OWN_SER0;
  endfunction
endpackage

// File: rtl/spm_sync.sv
module spm_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spm_regs.sv
module spm_regs
  import spm_pkg::*;
#(
  parameter int unsigned WIDTH = PORT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] pin_sync_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] dir_o
);
  logic [WIDTH-1:0] data_q, dir_q;

  // data register deliberately has no reset
  always_ff @(posedge clk_i) begin
    if (wr_i && addr_i == ADDR_DATA) data_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= '0;
    else if (wr_i && addr_i == ADDR_DIR) dir_q <= wdata_i;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_DATA: rdata_o = (data_q & dir_q) | (pin_sync_i & ~dir_q);
      ADDR_PIN:  rdata_o = pin_sync_i;
      ADDR_DIR:  rdata_o = dir_q;
      default:   rdata_o = '0;
    endcase
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/spm_owner.sv
module spm_owner
  import spm_pkg::*;
(
  input  logic              spi_en_i,
  input  logic              ser1_en_i,
  input  logic              ser0_en_i,
  input  logic [PORT_W-1:0] per_out_i,
  input  logic [PORT_W-1:0] per_oe_i,
  input  logic [PORT_W-1:0] gpio_out_i,
  input  logic [PORT_W-1:0] gpio_dir_i,
  output logic [PORT_W-1:0] pin_out_o,
  output logic [PORT_W-1:0] pin_oe_o
);
  for (genvar p = 0; p < PORT_W; p++) begin : g_pin
    localparam owner_e GRP = pin_group(p);
    owner_e owner;

    always_comb begin
      owner = OWN_GPIO;
      unique case (GRP)
        OWN_SPI:  if (spi_en_i)  owner = OWN_SPI;
        OWN_SER1: if (ser1_en_i) owner = OWN_SER1;
        OWN_SER0: if (ser0_en_i) owner = OWN_SER0;
        default:  owner = OWN_GPIO;
      endcase
    end

    assign pin_out_o[p] = (owner == OWN_GPIO) ? gpio_out_i[p] : per_out_i[p];
    assign pin_oe_o[p]  = (owner == OWN_GPIO) ? gpio_dir_i[p] : per_oe_i[p];
  end
endmodule

// File: rtl/serial_pin_mux.sv
module serial_pin_mux
  import spm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] bus_addr_i,
  input  logic       bus_wr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  input  logic       spi_en_i,
  input  logic       ser1_en_i,
  input  logic       ser0_en_i,
  input  logic [3:0] spi_out_i,
  input  logic [3:0] spi_oe_i,
  input  logic       ser1_txd_i,
  input  logic       ser1_tx_oe_i,
  input  logic       ser0_txd_i,
  input  logic       ser0_tx_oe_i,
  input  logic [7:0] pin_in_i,
  output logic [7:0] pin_out_o,
  output logic [7:0] pin_oe_o,
  output logic [3:0] spi_in_o,
  output logic       ser1_rxd_o,
  output logic       ser0_rxd_o
);
  logic [PORT_W-1:0] sync_w, data_w, dir_w, per_out_w, per_oe_w;

  spm_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_in_i),
    .q_o   (sync_w)
  );

  spm_regs #(.WIDTH(PORT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (bus_addr_i),
    .wr_i      (bus_wr_i),
    .wdata_i   (bus_wdata_i),
    .pin_sync_i(sync_w),
    .rdata_o   (bus_rdata_o),
    .data_o    (data_w),
    .dir_o     (dir_w)
  );

  // receive pins (2, 0) are forced to input when owned
  assign per_out_w = {spi_out_i, ser1_txd_i, 1'b0, ser0_txd_i, 1'b0};
  assign per_oe_w  = {spi_oe_i, ser1_tx_oe_i, 1'b0, ser0_tx_oe_i, 1'b0};

  spm_owner u_owner (
    .spi_en_i  (spi_en_i),
    .ser1_en_i (ser1_en_i),
    .ser0_en_i (ser0_en_i),
    .per_out_i (per_out_w),
    .per_oe_i  (per_oe_w),
    .gpio_out_i(data_w),
    .gpio_dir_i(dir_w),
    .pin_out_o (pin_out_o),
    .pin_oe_o  (pin_oe_o)
  );

  assign spi_in_o   = sync_w[7:4];
  assign ser1_rxd_o = sync_w[2];
  assign ser0_rxd_o = sync_w[0];
endmodule

// File: rtl/spm_chk.sv
module spm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] bus_addr_i,
  input logic [7:0] bus_rdata_o,
  input logic       spi_en_i,
  input logic       ser1_en_i,
  input logic       ser0_en_i,
  input logic [3:0] spi_oe_i,
  input logic [7:0] pin_in_i,
  input logic [7:0] pin_oe_o,
  input logic [7:0] dir_w
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R1
  always @(posedge clk_i) if (!rst_ni) dir_reset_chk: assert (dir_w == 8'h00);

  // R3
  spi_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_en_i |-> pin_oe_o[7:4] == spi_oe_i);

  // R4
  ser1_rx_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser1_en_i |-> !pin_oe_o[2]);

  // R5
  ser0_rx_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser0_en_i |-> !pin_oe_o[0]);

  // R6
  gpio_hi_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_en_i |-> pin_oe_o[7:4] == dir_w[7:4]);

  // R10
  unimpl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == 2'd3 |-> bus_rdata_o == 8'h00);

  // R11
  sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && bus_addr_i == 2'd1) |-> bus_rdata_o == $past(pin_in_i, 2));
endmodule

bind serial_pin_mux spm_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .spi_en_i   (spi_en_i),
  .ser1_en_i  (ser1_en_i),
  .ser0_en_i  (ser0_en_i),
  .spi_oe_i   (spi_oe_i),
  .pin_in_i   (pin_in_i),
  .pin_oe_o   (pin_oe_o),
  .dir_w      (dir_w)
);

// File: tb/sim_serial_pin_mux.sv
module sim_serial_pin_mux;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] bus_addr_i = '0;
  logic       bus_wr_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       spi_en_i = 1'b0, ser1_en_i = 1'b0, ser0_en_i = 1'b0;
  logic [3:0] spi_out_i = '0, spi_oe_i = '0;
  logic       ser1_txd_i = 1'b0, ser1_tx_oe_i = 1'b0, ser0_txd_i = 1'b0, ser0_tx_oe_i = 1'b0;
  logic [7:0] pin_in_i = '0;
  logic [7:0] pin_out_o, pin_oe_o;
  logic [3:0] spi_in_o;
  logic       ser1_rxd_o, ser0_rxd_o;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  serial_pin_mux u0 (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    tick();
    bus_wr_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    bus_addr_i = a;
    #1;
    check(req, bus_rdata_o, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [7:0] d, p, eo, ex;
    // R1: reset state
    tick(2);
    check("R1 oe in reset", pin_oe_o, 8'h00);
    rst_ni = 1'b1;
    tick();
    check("R1 oe after reset", pin_oe_o, 8'h00);
    rd_chk("R1 dir after reset", 2'd2, 8'h00);

    // R9: direction register
    wr(2'd2, 8'h96);
    rd_chk("R9 dir readback", 2'd2, 8'h96);

    // R2, R7: sweep every direction value, pins opposite to latched data
    for (int k = 0; k < 256; k++) begin
      d = 8'(k) ^ 8'h5A;
      p = ~d;
      pin_in_i = p;
      wr(2'd0, d);
      wr(2'd2, 8'(k));
      tick();
      rd_chk("R7 mixed read", 2'd0, (d & 8'(k)) | (p & ~8'(k)));
      check("R2 gpio oe", pin_oe_o, 8'(k));
      check("R2 gpio out", pin_out_o, d);
    end

    // R11: synchronizer latency
    wr(2'd2, 8'h00);
    pin_in_i = 8'h00;
    tick(3);
    pin_in_i = 8'hC5;
    tick(1);
    rd_chk("R11 one edge", 2'd1, 8'h00);
    check("R11 spi_in one edge", {4'h0, spi_in_o}, 8'h00);
    tick(1);
    rd_chk("R11 two edges", 2'd1, 8'hC5);
    rd_chk("R11 data read two edges", 2'd0, 8'hC5);
    check("R11 spi_in", {4'h0, spi_in_o}, 8'h0C);
    check("R11 ser1_rxd", {7'h0, ser1_rxd_o}, 8'h01);
    check("R11 ser0_rxd", {7'h0, ser0_rxd_o}, 8'h01);

    // R3..R6: every enable combination
    wr(2'd0, 8'h3C);
    wr(2'd2, 8'hFF);
    for (int e = 0; e < 8; e++) begin
      for (int v = 0; v < 4; v++) begin
        spi_en_i = e[2]; ser1_en_i = e[1]; ser0_en_i = e[0];
        spi_out_i = 4'(v * 5 + e); spi_oe_i = 4'(v * 3 + 9);
        ser1_txd_i = v[0]; ser1_tx_oe_i = v[1];
        ser0_txd_i = ~v[0]; ser0_tx_oe_i = v[0] ^ v[1];
        p = 8'(v * 37 + e * 11);
        pin_in_i = p;
        tick(2);
        ex = 8'h3C; eo = 8'hFF;
        if (e[2]) begin ex[7:4] = spi_out_i; eo[7:4] = spi_oe_i; end
        if (e[1]) begin ex[3] = ser1_txd_i; eo[3] = ser1_tx_oe_i; ex[2] = 1'b0; eo[2] = 1'b0; end
        if (e[0]) begin ex[1] = ser0_txd_i; eo[1] = ser0_tx_oe_i; ex[0] = 1'b0; eo[0] = 1'b0; end
        check(e[2] ? "R3 spi oe" : "R6 oe", pin_oe_o, eo);
        check(e[1] ? "R4 ser1 out" : (e[0] ? "R5 ser0 out" : "R6 out"), pin_out_o, ex);
        check("R11 spi_in", {4'h0, spi_in_o}, {4'h0, p[7:4]});
        check("R4 ser1 rxd", {7'h0, ser1_rxd_o}, {7'h0, p[2]});
        check("R5 ser0 rxd", {7'h0, ser0_rxd_o}, {7'h0, p[0]});
      end
    end
    spi_en_i = 0; ser1_en_i = 0; ser0_en_i = 0;

    // R8: input register ignores writes
    wr(2'd0, 8'hA7);
    wr(2'd2, 8'h0F);
    pin_in_i = 8'h00;
    tick(2);
    wr(2'd1, 8'hFF);
    rd_chk("R8 pin reg", 2'd1, 8'h00);
    rd_chk("R8 dir kept", 2'd2, 8'h0F);
    check("R8 data kept", pin_out_o, 8'hA7);

    // R10: unimplemented address
    wr(2'd3, 8'h55);
    rd_chk("R10 read zero", 2'd3, 8'h00);
    rd_chk("R10 dir kept", 2'd2, 8'h0F);
    check("R10 data kept", pin_out_o, 8'hA7);

    // R12: data survives reset
    wr(2'd0, 8'hA5);
    rst_ni = 1'b0;
    tick(2);
    check("R1 oe in reset", pin_oe_o, 8'h00);
    rst_ni = 1'b1;
    tick();
    rd_chk("R1 dir cleared", 2'd2, 8'h00);
    wr(2'd2, 8'hFF);
    rd_chk("R12 data kept", 2'd0, 8'hA5);
    check("R12 data on pins", pin_out_o, 8'hA5);

    finish_run();
  end
endmodule